// File: doc/BRIEF.md
# Dual Programmable Clock Output Generator

This block derives two divided clock outputs from a pair of source clock-enable strobes and routes them, together with other clock-like signals, onto two output pins. It runs entirely in one system clock domain. Every source clock is represented by a single-cycle enable strobe, and each output is a level that changes only on such strobes.

Each of the two channels owns a 16-bit half of a 32-bit control register. The fields in a half are an enable, a source choice, a 4-bit divide field and a 4-bit compare field. The compare field sets where in the period the output falls. When software writes a new divide value, the hardware replaces the compare field so that the output comes out near 50% duty. A second register holds two 3-bit output selectors. Each selector picks one of five external inputs, or the gated divided output of its own channel, or a constant low. New divide, source and compare values do not act at once: they are held until the running period ends, which prevents runt pulses.

Top module: `clkout_gen`

## Requirements
- R1: After reset both registers read 0, both divided outputs are low, and each selected output follows bit 0 of its external input bus.
- R2: The enable of channel c sits at control bit 16c. While that bit reads 0 the channel's divided output is low.
- R3: The source choice of channel c sits at control bit 16c+1. Value 0 counts strobes of src_tick_i[0], value 1 counts strobes of src_tick_i[1], and strobes of the other input do not advance the period.
- R4: The divide field of channel c is control bits 16c+7:16c+4, and the period is (field+1) strobes. A period counter runs from 0 to the field value and the output is high while the counter is at or below the active compare value.
- R5: The compare field of channel c is control bits 16c+11:16c+8. A control write whose divide field differs from the stored one stores floor(divide/2) as the compare value, which equals ((N+1)/2)-1 for ratio N. A write that leaves the divide field unchanged stores the written compare value.
- R6: New divide, source and compare values take effect only when the running period wraps. The divided output changes only on a strobe of the active source or in the two cycles after a control write.
- R7: Selector c is misc bits 6:4 (c=0) or 10:8 (c=1). Codes 0 to 4 route bit `code` of the channel's external input bus, and code 5 routes the divided output of the same channel.
- R8: Selector codes 6 and 7 drive the selected output low, and a read returns the stored code unchanged.
- R9: Reserved register bits read 0 whatever was written.
- R10: Setting a channel's enable starts a fresh period at counter 0 on the second clock edge after the write, so the output is high from then on for compare+1 strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 1 | Register select: 0 control, 1 misc (read and write) |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data of the addressed register (combinational) |
| src_tick_i | input | 2 | Enable strobes of the two divider sources |
| ext0_i | input | 5 | External choices 0 to 4 for output selector 0 |
| ext1_i | input | 5 | External choices 0 to 4 for output selector 1 |
| dclk_o | output | 2 | Gated divided output per channel |
| clkout_o | output | 2 | Selected output per selector |

## Verification
A wrong counter or wrong held configuration shows at dclk_o by the next strobe of the active source. Such a fault would stretch or clip the high phase, and the high-count test over a known number of strobes catches it within one period of at most 16 strobes. A wrong compare recomputation or wrong field masking is visible on rdata_o in the cycle right after the write. A wrong selector decode shows at clkout_o in the same cycle. The bench runs a cycle-level reference model and compares all three output groups on every cycle, so a divergence is reported in the cycle where it first appears.

// File: rtl/clkout_pkg.sv
package clkout_pkg;
  localparam int CH_N     = 2;
  localparam int HALF_W   = 16;
  localparam int REG_W    = CH_N * HALF_W;
  localparam int DIV_W    = 4;
  localparam int SEL_W    = 3;
  localparam int EXT_N    = 5;
  localparam int EN_BIT   = 0;
  localparam int SRC_BIT  = 1;
  localparam int DIV_LSB  = 4;
  localparam int CMP_LSB  = 8;
  localparam int SEL_LSB  = 4;
  localparam int SEL_STEP = 4;

  typedef struct packed {
    logic             en;
    logic             src;
    logic [DIV_W-1:0] div;
    logic [DIV_W-1:0] cmp;
  } ch_cfg_t;

  function automatic ch_cfg_t unpack_half(input logic [HALF_W-1:0] h);
    ch_cfg_t c;
    c.en  = h[EN_BIT];
    c.src = h[SRC_BIT];
    c.div = h[DIV_LSB +: DIV_W];
    c.cmp = h[CMP_LSB +: DIV_W];
    return c;
  endfunction

  function automatic logic [HALF_W-1:0] pack_half(input ch_cfg_t c);
    logic [HALF_W-1:0] h;
    h = '0;
    h[EN_BIT]            = c.en;
    h[SRC_BIT]           = c.src;
    h[DIV_LSB +: DIV_W]  = c.div;
    h[CMP_LSB +: DIV_W]  = c.cmp;
    return h;
  endfunction

  // ratio N = div+1; ((N+1)/2)-1 reduces to div/2
  function automatic logic [DIV_W-1:0] half_cmp(input logic [DIV_W-1:0] div);
    return div >> 1;
  endfunction
endpackage

// File: rtl/clkout_regs.sv
module clkout_regs
  import clkout_pkg::*;
#(
  parameter int CH = CH_N
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      wr_en_i,
  input  logic                      addr_i,
  input  logic [REG_W-1:0]          wdata_i,
  output ch_cfg_t [CH-1:0]          cfg_o,
  output logic [CH-1:0][SEL_W-1:0]  sel_o,
  output logic [REG_W-1:0]          ctrl_o,
  output logic [REG_W-1:0]          misc_o
);
  ch_cfg_t [CH-1:0]         cfg_q, cfg_nxt;
  logic [CH-1:0][SEL_W-1:0] sel_q;

  for (genvar c = 0; c < CH; c++) begin : g_half
    ch_cfg_t w;
    assign w = unpack_half(wdata_i[c*HALF_W +: HALF_W]);
    assign cfg_nxt[c] = '{en:  w.en,
                          src: w.src,
                          div: w.div,
                          cmp: (w.div != cfg_q[c].div) ? half_cmp(w.div) : w.cmp};
    assign ctrl_o[c*HALF_W +: HALF_W] = pack_half(cfg_q[c]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
      sel_q <= '0;
    end else if (wr_en_i) begin
      if (!addr_i) begin
        cfg_q <= cfg_nxt;
      end else begin
        for (int c = 0; c < CH; c++) sel_q[c] <= wdata_i[SEL_LSB + c*SEL_STEP +: SEL_W];
      end
    end
  end

  always_comb begin
    misc_o = '0;
    for (int c = 0; c < CH; c++) misc_o[SEL_LSB + c*SEL_STEP +: SEL_W] = sel_q[c];
  end

  assign cfg_o = cfg_q;
  assign sel_o = sel_q;
endmodule

// File: rtl/clkout_chan.sv
module clkout_chan
  import clkout_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  ch_cfg_t    cfg_i,
  input  logic [1:0] tick_i,
  output logic       dclk_o
);
  logic             run_q;
  logic [DIV_W-1:0] cnt_q;
  ch_cfg_t          act_q;
  logic             tick;

  assign tick = tick_i[act_q.src];

  // act_q holds the config of the running period; reloaded at start and wrap
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      cnt_q <= '0;
      act_q <= '0;
    end else if (!cfg_i.en || !run_q) begin
      run_q <= cfg_i.en;
      cnt_q <= '0;
      act_q <= cfg_i;
    end else if (tick) begin
      if (cnt_q == act_q.div) begin
        cnt_q <= '0;
        act_q <= cfg_i;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign dclk_o = run_q && cfg_i.en && (cnt_q <= act_q.cmp);
endmodule

// File: rtl/clkout_sel.sv
module clkout_sel
  import clkout_pkg::*;
#(
  parameter int N_EXT = EXT_N
) (
  input  logic [SEL_W-1:0] sel_i,
  input  logic [N_EXT-1:0] ext_i,
  input  logic             dclk_i,
  output logic             out_o
);
  always_comb begin
    out_o = 1'b0;
    for (int k = 0; k < N_EXT; k++)
      if (sel_i == SEL_W'(k)) out_o = ext_i[k];
    if (sel_i == SEL_W'(N_EXT)) out_o = dclk_i;
  end
endmodule

// File: rtl/clkout_gen.sv
module clkout_gen
  import clkout_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic             addr_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] rdata_o,
  input  logic [1:0]       src_tick_i,
  input  logic [EXT_N-1:0] ext0_i,
  input  logic [EXT_N-1:0] ext1_i,
  output logic [CH_N-1:0]  dclk_o,
  output logic [CH_N-1:0]  clkout_o
);
  ch_cfg_t [CH_N-1:0]         cfg;
  logic [CH_N-1:0][SEL_W-1:0] sel;
  logic [REG_W-1:0]           ctrl_q, misc_q;
  logic [CH_N-1:0][EXT_N-1:0] ext_all;

  assign ext_all = {ext1_i, ext0_i};

  clkout_regs #(.CH(CH_N)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (wr_en_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .cfg_o   (cfg),
    .sel_o   (sel),
    .ctrl_o  (ctrl_q),
    .misc_o  (misc_q)
  );

  for (genvar c = 0; c < CH_N; c++) begin : g_ch
    clkout_chan u_chan (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .cfg_i  (cfg[c]),
      .tick_i (src_tick_i),
      .dclk_o (dclk_o[c])
    );
    clkout_sel #(.N_EXT(EXT_N)) u_sel (
      .sel_i  (sel[c]),
      .ext_i  (ext_all[c]),
      .dclk_i (dclk_o[c]),
      .out_o  (clkout_o[c])
    );
  end

  assign rdata_o = addr_i ? misc_q : ctrl_q;
endmodule

// File: rtl/clkout_gen_chk.sv
module clkout_gen_chk
  import clkout_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_en_i,
  input logic             addr_i,
  input logic [REG_W-1:0] wdata_i,
  input logic [1:0]       src_tick_i,
  input logic [CH_N-1:0]  dclk_o,
  input logic [CH_N-1:0]  clkout_o,
  input logic [REG_W-1:0] ctrl_q,
  input logic [REG_W-1:0] misc_q
);
  for (genvar c = 0; c < CH_N; c++) begin : g_a
    localparam int B = c * HALF_W;
    localparam int S = SEL_LSB + c * SEL_STEP;

    AST_DIS_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !ctrl_q[B+EN_BIT] |-> !dclk_o[c]); // R2

    AST_CMP_HALF: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && !addr_i && (wdata_i[B+DIV_LSB +: DIV_W] != ctrl_q[B+DIV_LSB +: DIV_W]))
      |=> (ctrl_q[B+CMP_LSB +: DIV_W] == (ctrl_q[B+DIV_LSB +: DIV_W] >> 1))); // R5

    AST_QUIET_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (src_tick_i == 2'b00 && !wr_en_i && !$past(wr_en_i)) |=> $stable(dclk_o[c])); // R6

    AST_SEL_DCLK: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (misc_q[S +: SEL_W] == 3'd5) |-> (clkout_o[c] == dclk_o[c])); // R7

    AST_SEL_RSVD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (misc_q[S +: SEL_W] >= 3'd6) |-> !clkout_o[c]); // R8
  end
endmodule

bind clkout_gen clkout_gen_chk u_chk (.*);

// File: tb/clkout_gen_bench.sv
module clkout_gen_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        addr = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [1:0]  tick = '0;
  logic [4:0]  ext0 = 5'b00001;
  logic [4:0]  ext1 = 5'b11110;
  logic [1:0]  dclk, clkout;
  int checks = 0, errors = 0;
  logic chk_on = 1'b0;

  always #10 clk = ~clk;

  clkout_gen u_clkout_gen (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .src_tick_i(tick), .ext0_i(ext0), .ext1_i(ext1),
    .dclk_o(dclk), .clkout_o(clkout)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // reference model built from the requirements
  function automatic logic [31:0] next_ctrl(input logic [31:0] old, input logic [31:0] w);
    logic [31:0] r;
    r = '0;
    for (int c = 0; c < 2; c++) begin
      r[16*c]          = w[16*c];
      r[16*c+1]        = w[16*c+1];
      r[16*c+4 +: 4]   = w[16*c+4 +: 4];
      r[16*c+8 +: 4]   = (w[16*c+4 +: 4] != old[16*c+4 +: 4]) ? (w[16*c+4 +: 4] >> 1) : w[16*c+8 +: 4];
    end
    return r;
  endfunction

  function automatic logic sel_out(input logic [2:0] s, input logic [4:0] e, input logic d);
    if (s < 3'd5) return e[s];
    if (s == 3'd5) return d;
    return 1'b0;
  endfunction

  logic [31:0] m_ctrl, m_misc;
  logic        m_run [2];
  logic        m_src [2];
  logic [3:0]  m_cnt [2];
  logic [3:0]  m_div [2];
  logic [3:0]  m_cmp [2];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ctrl <= '0; m_misc <= '0;
      for (int c = 0; c < 2; c++) begin
        m_run[c] <= 0; m_src[c] <= 0; m_cnt[c] <= 0; m_div[c] <= 0; m_cmp[c] <= 0;
      end
    end else begin
      if (wr_en && !addr) m_ctrl <= next_ctrl(m_ctrl, wdata);
      if (wr_en && addr)  m_misc <= wdata & 32'h0000_0770;
      for (int c = 0; c < 2; c++) begin
        if (!m_ctrl[16*c] || !m_run[c] || (tick[m_src[c]] && m_cnt[c] == m_div[c])) begin
          m_run[c] <= m_ctrl[16*c];
          m_cnt[c] <= 0;
          m_src[c] <= m_ctrl[16*c+1];
          m_div[c] <= m_ctrl[16*c+4 +: 4];
          m_cmp[c] <= m_ctrl[16*c+8 +: 4];
        end else if (tick[m_src[c]]) begin
          m_cnt[c] <= m_cnt[c] + 1;
        end
      end
    end
  end

  function automatic logic exp_dclk(input int c);
    return m_run[c] && m_ctrl[16*c] && (m_cnt[c] <= m_cmp[c]);
  endfunction

  // cycle-level comparison, away from the active edge
  always @(negedge clk) begin
    #1;
    if (rst_n && chk_on) begin
      logic [1:0] ed;
      ed = {exp_dclk(1), exp_dclk(0)};
      chk("R3 R4 R6 R10 dclk", {30'b0, dclk}, {30'b0, ed});
      chk("R7 R8 clkout", {30'b0, clkout},
          {30'b0, sel_out(m_misc[10:8], ext1, ed[1]), sel_out(m_misc[6:4], ext0, ed[0])});
      chk("R5 R9 rdata", rdata, addr ? m_misc : m_ctrl);
    end
  end

  task automatic wr(input logic a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic a, input string req, input logic [31:0] exp);
    @(negedge clk);
    addr = a;
    #2;
    chk(req, rdata, exp);
  endtask

  initial begin
    repeat (3000) @(posedge clk);
    repeat (147000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int highs;
    void'($urandom(32'd2024));
    // R1: reset state
    repeat (2) @(negedge clk);
    #2;
    chk("R1 rdata ctrl", rdata, 32'h0);
    chk("R1 dclk", {30'b0, dclk}, 32'h0);
    chk("R1 clkout", {30'b0, clkout}, {30'b0, ext1[0], ext0[0]});
    addr = 1'b1; #1;
    chk("R1 rdata misc", rdata, 32'h0);
    @(negedge clk); rst_n = 1'b1; addr = 1'b0;
    chk_on = 1'b1;

    // R4 R10: ratio 3, tick every cycle -> high 2 of 3
    tick = 2'b01;
    wr(1'b0, 32'h0000_0021);
    rd(1'b0, "R5 cmp after div 2", 32'h0000_0121);
    highs = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk); #2;
      if (dclk[0]) highs++;
    end
    chk("R4 R10 high count ratio 3", highs, 20);
    // R3: only the other source ticks -> output frozen
    tick = 2'b10;
    @(negedge clk); #2;
    begin
      logic hold;
      hold = dclk[0];
      repeat (5) @(negedge clk);
      #2;
      chk("R3 unselected source ignored", {31'b0, dclk[0]}, {31'b0, hold});
    end
    // R2: enable clear forces low
    wr(1'b0, 32'h0000_0120);
    #2;
    chk("R2 disabled low", {31'b0, dclk[0]}, 32'h0);
    // R5: div change recomputes, same div keeps written cmp
    wr(1'b0, 32'h0000_00F1);
    rd(1'b0, "R5 div 15 cmp 7", 32'h0000_07F1);
    wr(1'b0, 32'h0000_03F1);
    rd(1'b0, "R5 same div keeps cmp", 32'h0000_03F1);
    // R9: reserved bits
    wr(1'b0, 32'hFFFF_FFFF);
    rd(1'b0, "R9 ctrl reserved", 32'h07F3_0FF3);
    wr(1'b1, 32'hFFFF_FFFF);
    rd(1'b1, "R9 misc reserved", 32'h0000_0770);
    // R8: reserved select codes
    ext0 = 5'b11111; ext1 = 5'b11111;
    wr(1'b1, 32'h0000_0060);
    rd(1'b1, "R8 readback 6", 32'h0000_0060);
    chk("R8 code 6 low", {31'b0, clkout[0]}, 32'h0);
    wr(1'b1, 32'h0000_0700);
    #2;
    chk("R8 code 7 low", {31'b0, clkout[1]}, 32'h0);
    // R7: code 3 routes ext bit 3, code 5 routes dclk
    ext0 = 5'b01000;
    wr(1'b1, 32'h0000_0530);
    #2;
    chk("R7 code 3 ext", {31'b0, clkout[0]}, 32'h1);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      wr_en = 1'b0;
      tick  = 2'($urandom_range(0, 3));
      ext0  = 5'($urandom);
      ext1  = 5'($urandom);
      addr  = 1'($urandom);
      if ($urandom_range(0, 24) == 0) begin
        wr_en = 1'b1;
        wdata = $urandom;
        if (!addr && $urandom_range(0, 3) != 0) wdata = wdata | 32'h0001_0001;
      end
    end
    @(negedge clk); wr_en = 1'b0;
    repeat (3) @(negedge clk);
    #3;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule